// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer of 256 words of 18 bits. It sits between two unrelated clock domains. The producer pushes words on its own clock with an active-low write enable. The consumer pulls words into a registered output on its own clock with an active-low read enable. Each domain keeps a binary pointer one bit wider than the address. The pointer is sent to the other domain in Gray code through a two-flop synchronizer, and each side computes its flags from its own pointer and the synchronized copy of the other.

Four active-low flags report the fill level. Each flag is registered in the domain that uses it. Empty and almost-empty belong to the read clock, and full and almost-full belong to the write clock. The two almost thresholds come from static inputs. When the buffer is full, further writes are dropped. When it is empty, further reads are dropped and the output keeps its last valid word.

A retransmit pulse moves the read pointer back to storage location 0, so a short packet can be replayed. An active-low output enable either drives the output register onto the data pins or releases the pins to high impedance. A single asynchronous active-low reset input is synchronized into each clock domain before it is released.

Top module: `dual_clk_prog_fifo`

## Requirements
- R1: A write-clock rising edge with `wr_en_n` low and `full_n` high stores `wr_data`. Stored words come out in the order they were written, even when both clocks run at the same time.
- R2: While `full_n` is low, a write-clock edge stores nothing, whatever `wr_en_n` is. From empty, exactly 256 writes are accepted.
- R3: A read-clock rising edge with `rd_en_n` low and `empty_n` high loads the oldest stored word into the output register. The word is on `rd_data` right after that edge when `oe_n` is low.
- R4: While `empty_n` is low, a read-clock edge with `rd_en_n` low changes nothing, and `rd_data` keeps the last word that was read.
- R5: After reset, `empty_n` is 0, `aempty_n` is 0, `full_n` is 1 and `afull_n` is 1. The output register holds 0.
- R6: When no traffic is running, `empty_n` is 0 exactly when the stored count is 0, and `full_n` is 0 exactly when the count is 256.
- R7: When no traffic is running, `aempty_n` is 0 exactly when count <= `ae_level`. An empty buffer always shows `aempty_n` low.
- R8: When no traffic is running, `afull_n` is 0 exactly when count + `af_level` >= 256. A full buffer always shows `afull_n` low.
- R9: A read-clock edge with `retx` high sets the read pointer to location 0 and overrides any read in that cycle. The count is then recomputed, and later reads replay the words from the first one written since reset.
- R10: With `oe_n` high, `rd_data` is released to high impedance. With `oe_n` low, it shows the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_en_n | input | 1 | Active-low write enable |
| wr_data | input | 18 | Word to store |
| rd_en_n | input | 1 | Active-low read enable |
| oe_n | input | 1 | Active-low output enable for `rd_data` |
| retx | input | 1 | Retransmit: rewind the read pointer to location 0 (read clock) |
| ae_level | input | 9 | Almost-empty threshold, in words |
| af_level | input | 9 | Almost-full threshold, in words below capacity |
| rd_data | output | 18 | Output register, or high impedance when `oe_n` is high |
| empty_n | output | 1 | Low when the buffer is empty (read clock) |
| aempty_n | output | 1 | Low when the count is at or below `ae_level` (read clock) |
| full_n | output | 1 | Low when the buffer holds 256 words (write clock) |
| afull_n | output | 1 | Low when the count is within `af_level` of capacity (write clock) |

## Verification
The hardest state to reach is a write attempt while the buffer is full, at the moment the read side is draining it. There the write side still sees a stale read pointer, so `full_n` stays low a few cycles longer than the true count would allow. The stimulus reaches this state by filling the buffer from an idle read side with 270 back-to-back write attempts. It then runs long concurrent phases with biased enable rates on the two unrelated clocks, so the buffer spends many cycles pinned against full and against empty. Every accepted transfer is decided from the flags seen at the ports and checked against a reference array. The threshold boundaries (count equal to the level and one past it) and retransmit are reached by directed sequences from a fresh reset, with both sides left idle before each flag check.

// File: rtl/fifo_pkg.sv
`timescale 1ns/1ps
package fifo_pkg;
  // Registered pair of level flags for one clock domain (both active low)
  typedef struct packed {
    logic edge_n;  // empty or full
    logic near_n;  // almost empty or almost full
  } lvl_flags_t;
endpackage

// File: rtl/fifo_rst_sync.sv
`timescale 1ns/1ps
module fifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage <= 2'b00;
    else         stage <= {stage[0], 1'b1};
  end

  assign srst_n = stage[1];
endmodule

// File: rtl/fifo_gray_xfer.sv
`timescale 1ns/1ps
module fifo_gray_xfer #(
  parameter int PW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  // Gray to binary: each bit is the XOR of all Gray bits at or above it
  always_comb begin
    bin_out[PW-1] = sync_q[PW-1];
    for (int i = PW - 2; i >= 0; i--) bin_out[i] = bin_out[i+1] ^ sync_q[i];
  end
endmodule

// File: rtl/fifo_ram.sv
`timescale 1ns/1ps
module fifo_ram #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/fifo_wr_side.sv
`timescale 1ns/1ps
module fifo_wr_side
  import fifo_pkg::*;
#(
  parameter int AW = 8,
  localparam int PW = AW + 1
) (
  input  logic          wr_clk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic [PW-1:0] af_level,
  input  logic [PW-1:0] r_bin_s,
  output logic          we,
  output logic [PW-1:0] w_bin,
  output logic [PW-1:0] w_gray,
  output lvl_flags_t    flags
);
  localparam logic [PW-1:0] CAP   = PW'(1) << AW;
  localparam logic [PW:0]   CAP_X = (PW+1)'(1) << AW;

  logic [PW-1:0] w_bin_d, cnt_d;
  logic [PW:0]   sum_d;
  lvl_flags_t    flags_d;

  always_comb begin
    we             = !wr_en_n && flags.edge_n;
    w_bin_d        = we ? w_bin + 1'b1 : w_bin;
    cnt_d          = w_bin_d - r_bin_s;
    sum_d          = {1'b0, cnt_d} + {1'b0, af_level};
    flags_d.edge_n = (cnt_d != CAP);
    flags_d.near_n = (sum_d < CAP_X);
  end

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      w_bin  <= '0;
      w_gray <= '0;
      flags  <= '{edge_n: 1'b1, near_n: 1'b1};
    end else begin
      w_bin  <= w_bin_d;
      w_gray <= w_bin_d ^ (w_bin_d >> 1);
      flags  <= flags_d;
    end
  end
endmodule

// File: rtl/fifo_rd_side.sv
`timescale 1ns/1ps
module fifo_rd_side
  import fifo_pkg::*;
#(
  parameter int AW = 8,
  localparam int PW = AW + 1
) (
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          rd_en_n,
  input  logic          retx,
  input  logic [PW-1:0] ae_level,
  input  logic [PW-1:0] w_bin_s,
  output logic          re,
  output logic [PW-1:0] r_bin,
  output logic [PW-1:0] r_gray,
  output lvl_flags_t    flags
);
  logic [PW-1:0] r_bin_d, cnt_d;
  lvl_flags_t    flags_d;

  always_comb begin
    // Retransmit wins over a read in the same cycle
    re = !rd_en_n && flags.edge_n && !retx;
    if (retx)    r_bin_d = '0;
    else if (re) r_bin_d = r_bin + 1'b1;
    else         r_bin_d = r_bin;
    cnt_d          = w_bin_s - r_bin_d;
    flags_d.edge_n = (cnt_d != '0);
    flags_d.near_n = (cnt_d > ae_level);
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      r_bin  <= '0;
      r_gray <= '0;
      flags  <= '{edge_n: 1'b0, near_n: 1'b0};
    end else begin
      r_bin  <= r_bin_d;
      r_gray <= r_bin_d ^ (r_bin_d >> 1);
      flags  <= flags_d;
    end
  end
endmodule

// File: rtl/dual_clk_prog_fifo.sv
`timescale 1ns/1ps
module dual_clk_prog_fifo
  import fifo_pkg::*;
#(
  parameter int DW = 18,
  parameter int AW = 8,
  localparam int PW = AW + 1
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en_n,
  input  logic          oe_n,
  input  logic          retx,
  input  logic [PW-1:0] ae_level,
  input  logic [PW-1:0] af_level,
  output logic [DW-1:0] rd_data,
  output logic          empty_n,
  output logic          aempty_n,
  output logic          full_n,
  output logic          afull_n
);
  logic          w_rst_n, r_rst_n;
  logic          we, re;
  logic [PW-1:0] w_bin, w_gray, r_bin, r_gray, w_bin_s, r_bin_s;
  logic [DW-1:0] ram_q, q_reg;
  lvl_flags_t    w_flags, r_flags;

  fifo_rst_sync u_wrst (.clk(wr_clk), .arst_n(rst_n), .srst_n(w_rst_n));
  fifo_rst_sync u_rrst (.clk(rd_clk), .arst_n(rst_n), .srst_n(r_rst_n));

  fifo_wr_side #(.AW(AW)) u_wr (
    .wr_clk(wr_clk), .rst_n(w_rst_n), .wr_en_n(wr_en_n), .af_level(af_level),
    .r_bin_s(r_bin_s), .we(we), .w_bin(w_bin), .w_gray(w_gray), .flags(w_flags)
  );

  fifo_rd_side #(.AW(AW)) u_rd (
    .rd_clk(rd_clk), .rst_n(r_rst_n), .rd_en_n(rd_en_n), .retx(retx),
    .ae_level(ae_level), .w_bin_s(w_bin_s), .re(re), .r_bin(r_bin),
    .r_gray(r_gray), .flags(r_flags)
  );

  fifo_gray_xfer #(.PW(PW)) u_w2r (
    .clk(rd_clk), .rst_n(r_rst_n), .gray_in(w_gray), .bin_out(w_bin_s)
  );
  fifo_gray_xfer #(.PW(PW)) u_r2w (
    .clk(wr_clk), .rst_n(w_rst_n), .gray_in(r_gray), .bin_out(r_bin_s)
  );

  fifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .wr_clk(wr_clk), .we(we), .waddr(w_bin[AW-1:0]), .wdata(wr_data),
    .raddr(r_bin[AW-1:0]), .rdata(ram_q)
  );

  // Output register: loads only on an accepted read, so it holds on empty
  always_ff @(posedge rd_clk or negedge r_rst_n) begin
    if (!r_rst_n)  q_reg <= '0;
    else if (re)   q_reg <= ram_q;
  end

  assign rd_data  = oe_n ? {DW{1'bz}} : q_reg;
  assign empty_n  = r_flags.edge_n;
  assign aempty_n = r_flags.near_n;
  assign full_n   = w_flags.edge_n;
  assign afull_n  = w_flags.near_n;
endmodule

module dual_clk_prog_fifo_sva #(
  parameter int DW = 18,
  parameter int PW = 9
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          w_rst_n,
  input logic          r_rst_n,
  input logic          wr_en_n,
  input logic          rd_en_n,
  input logic          retx,
  input logic          full_n,
  input logic          afull_n,
  input logic          empty_n,
  input logic          aempty_n,
  input logic [PW-1:0] w_bin,
  input logic [PW-1:0] r_bin,
  input logic [DW-1:0] q_reg
);
  p_wr_advance_r1: assert property (@(posedge wr_clk) disable iff (!w_rst_n)
    (!wr_en_n && full_n) |=> (w_bin == $past(w_bin) + 1'b1));

  p_no_overflow_r2: assert property (@(posedge wr_clk) disable iff (!w_rst_n)
    (!full_n) |=> $stable(w_bin));

  p_no_underflow_r4: assert property (@(posedge rd_clk) disable iff (!r_rst_n)
    (!empty_n && !retx) |=> $stable(r_bin));

  p_hold_output_r4: assert property (@(posedge rd_clk) disable iff (!r_rst_n)
    (!empty_n && !retx) |=> $stable(q_reg));

  p_empty_in_ae_r7: assert property (@(posedge rd_clk) disable iff (!r_rst_n)
    (!empty_n) |-> (!aempty_n));

  p_full_in_af_r8: assert property (@(posedge wr_clk) disable iff (!w_rst_n)
    (!full_n) |-> (!afull_n));

  p_rewind_r9: assert property (@(posedge rd_clk) disable iff (!r_rst_n)
    retx |=> (r_bin == '0));
endmodule

bind dual_clk_prog_fifo dual_clk_prog_fifo_sva #(.DW(DW), .PW(PW)) u_sva (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .w_rst_n(w_rst_n), .r_rst_n(r_rst_n),
  .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .retx(retx), .full_n(full_n),
  .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n),
  .w_bin(w_bin), .r_bin(r_bin), .q_reg(q_reg)
);

// File: tb/test_dual_clk_prog_fifo.sv
`timescale 1ns/1ps
module test_dual_clk_prog_fifo;
  localparam int DW  = 18;
  localparam int AW  = 8;
  localparam int PW  = AW + 1;
  localparam int CAP = 1 << AW;

  logic          wr_clk, rd_clk, rst_n;
  logic          wr_en_n, rd_en_n, oe_n, retx;
  logic [DW-1:0] wr_data;
  logic [PW-1:0] ae_level, af_level;
  wire  [DW-1:0] rd_data;
  logic          empty_n, aempty_n, full_n, afull_n;

  dual_clk_prog_fifo #(.DW(DW), .AW(AW)) i_dual_clk_prog_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en_n(wr_en_n),
    .wr_data(wr_data), .rd_en_n(rd_en_n), .oe_n(oe_n), .retx(retx),
    .ae_level(ae_level), .af_level(af_level), .rd_data(rd_data),
    .empty_n(empty_n), .aempty_n(aempty_n), .full_n(full_n), .afull_n(afull_n)
  );

  initial wr_clk = 1'b0;
  always #5 wr_clk = ~wr_clk;
  initial rd_clk = 1'b0;
  always #6.5 rd_clk = ~rd_clk;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [DW-1:0] mdl [CAP];
  int wi = 0;
  int ri = 0;
  int acc_w = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Write attempts; acceptance decided from full_n seen at the port
  task automatic wr_burst(input int n, input int pct);
    for (int k = 0; k < n; k++) begin
      @(negedge wr_clk);
      wr_en_n = !(($urandom % 100) < pct);
      wr_data = DW'($urandom) | DW'(1);
      if (!wr_en_n && full_n) begin
        chk((wi - ri) < CAP, "R2 write accepted beyond capacity", wi - ri, CAP - 1);
        mdl[wi % CAP] = wr_data;
        wi++;
        acc_w++;
      end
    end
    @(negedge wr_clk);
    wr_en_n = 1'b1;
  endtask

  // Read attempts; each accepted read is checked one edge later
  task automatic rd_burst(input int n, input int pct, input string tag);
    bit pend = 1'b0;
    logic [DW-1:0] exp_w = '0;
    for (int k = 0; k <= n; k++) begin
      @(negedge rd_clk);
      if (pend) chk(rd_data == exp_w, tag, rd_data, exp_w);
      pend = 1'b0;
      rd_en_n = (k == n) ? 1'b1 : !(($urandom % 100) < pct);
      if (!rd_en_n && empty_n) begin
        exp_w = mdl[ri % CAP];
        ri++;
        pend = 1'b1;
      end
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
    repeat (8) @(negedge wr_clk);
    @(negedge rd_clk);
  endtask

  task automatic check_flags(input string ctx);
    int c = wi - ri;
    chk(empty_n == (c != 0), {"R6 empty_n ", ctx}, empty_n, c != 0);
    chk(full_n == (c != CAP), {"R6 full_n ", ctx}, full_n, c != CAP);
    chk(aempty_n == !(c <= int'(ae_level)), {"R7 aempty_n ", ctx}, aempty_n,
        !(c <= int'(ae_level)));
    chk(afull_n == !(c + int'(af_level) >= CAP), {"R8 afull_n ", ctx}, afull_n,
        !(c + int'(af_level) >= CAP));
  endtask

  task automatic do_reset();
    wr_en_n = 1'b1;
    rd_en_n = 1'b1;
    retx    = 1'b0;
    rst_n   = 1'b0;
    repeat (4) @(negedge wr_clk);
    rst_n = 1'b1;
    wi = 0;
    ri = 0;
    settle();
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] last;
    void'($urandom(32'h5EED_F1F0));
    rst_n = 1'b0;
    oe_n = 1'b0;
    ae_level = 9'd4;
    af_level = 9'd4;
    wr_data = '0;
    do_reset();

    // R5: reset state
    chk(empty_n == 1'b0, "R5 empty_n after reset", empty_n, 0);
    chk(aempty_n == 1'b0, "R5 aempty_n after reset", aempty_n, 0);
    chk(full_n == 1'b1, "R5 full_n after reset", full_n, 1);
    chk(afull_n == 1'b1, "R5 afull_n after reset", afull_n, 1);
    chk(rd_data == '0, "R5 output register after reset", rd_data, 0);

    // R2: fill from empty with more attempts than capacity
    acc_w = 0;
    wr_burst(270, 100);
    settle();
    chk(acc_w == CAP, "R2 writes accepted from empty", acc_w, CAP);
    check_flags("when full");

    // R3: drain fully, checking order
    rd_burst(300, 100, "R3 read data in order");
    settle();
    check_flags("when drained");

    // R4: reads on empty leave output alone
    last = rd_data;
    chk(last == mdl[(ri - 1) % CAP], "R4 output shows last read word", last,
        mdl[(ri - 1) % CAP]);
    for (int k = 0; k < 6; k++) begin
      @(negedge rd_clk);
      rd_en_n = 1'b0;
      @(negedge rd_clk);
      chk(rd_data == last, "R4 output held on empty read", rd_data, last);
      chk(empty_n == 1'b0, "R4 stays empty", empty_n, 0);
    end
    rd_en_n = 1'b1;

    // R7: almost-empty boundary around ae_level = 4
    for (int n = 3; n <= 5; n++) begin
      wr_burst(1, 100);
      if (n == 3) wr_burst(2, 100);
      settle();
      check_flags($sformatf("R7 boundary count=%0d", wi - ri));
    end
    // R8: almost-full boundary around af_level = 4 (count 251..253)
    wr_burst(246, 100);
    settle();
    for (int n = 0; n < 3; n++) begin
      check_flags($sformatf("R8 boundary count=%0d", wi - ri));
      wr_burst(1, 100);
      settle();
    end
    // Other thresholds, same count
    ae_level = 9'd300;
    af_level = 9'd0;
    settle();
    check_flags("R7 R8 alternate levels");
    ae_level = 9'd4;
    af_level = 9'd4;
    rd_burst(300, 100, "R3 drain after threshold sweep");
    settle();

    // R1: concurrent random traffic, biased toward full and toward empty
    fork
      wr_burst(3000, 85);
      rd_burst(2300, 40, "R1 concurrent data order (fill bias)");
    join
    settle();
    check_flags("R1 after fill-biased traffic");
    fork
      wr_burst(2500, 30);
      rd_burst(2300, 90, "R1 concurrent data order (drain bias)");
    join
    settle();
    check_flags("R1 after drain-biased traffic");
    fork
      wr_burst(3000, 55);
      rd_burst(2300, 70, "R1 concurrent data order (mixed)");
    join
    rd_burst(400, 100, "R1 final drain");
    settle();
    check_flags("R1 after mixed traffic");

    // R9: retransmit from a fresh reset
    do_reset();
    chk(rd_data == '0, "R5 output register after second reset", rd_data, 0);
    wr_burst(10, 100);
    settle();
    rd_burst(6, 100, "R9 first pass read");
    settle();
    @(negedge rd_clk);
    retx = 1'b1;
    rd_en_n = 1'b0;
    @(negedge rd_clk);
    retx = 1'b0;
    rd_en_n = 1'b1;
    ri = 0;
    settle();
    check_flags("R9 after rewind");
    chk(aempty_n == 1'b1, "R9 count recomputed to 10", aempty_n, 1);
    rd_burst(20, 100, "R9 replay from location 0");
    settle();
    chk(ri == 10, "R9 replayed word count", ri, 10);
    check_flags("R9 after replay");

    // R10: output enable
    last = rd_data;
    oe_n = 1'b1;
    #1;
    chk(rd_data !== last, "R10 released when oe_n high", rd_data, last);
    oe_n = 1'b0;
    #1;
    chk(rd_data === last, "R10 driven when oe_n low", rd_data, last);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule